// File: doc/BRIEF.md
# Power Domain Vote Controller

This block collects power votes for a set of power domains and drives one power request line per domain towards its power switch. Software on the application processor votes through a small register bus: it writes a one to a domain's bit in the power-on command register or in the power-off command register. Remote processors vote through dedicated vote inputs. A domain is kept powered while any requester votes for it. Each domain has a power request output and a power acknowledge input from its switch.

Every domain has its own command engine. The engine accepts one command at a time and drives the request line. It waits for the acknowledge to match the requested state. After a power-off it also waits a programmable settling interval before it reports the domain idle again. Software follows progress through per-domain status bits. The two command registers read back a handshake, so software can see when the engine has taken the command.

Top module: `pwr_vote_ctrl`

## Requirements
- R1: Domain d uses bit d in every register. The register byte offsets are: 0x00 power-on command, 0x04 power-off command, 0x08 idle, 0x0C enabled, 0x10 on-pending, 0x14 off-pending, 0x18 error (write 1 to clear). Writes to the idle, enabled and pending offsets have no effect.
- R2: The idle bit is 1 while the domain's engine can take a command. It is 0 from the clock edge that accepts a command until that command has finished.
- R3: After reset the power-on command register reads all ones. Writing 1 to bit d makes bit d read 0 on the next cycle. Bit d reads 1 again one cycle later, once the engine has started the command.
- R4: After reset the power-off command register reads all zeros. Writing 1 to bit d makes bit d read 1 on the next cycle. Bit d drops back to 0 one cycle later, once the engine has started the command.
- R5: An accepted power-on for an unpowered domain raises its request output and its enabled bit. The on-pending bit stays 1 until the acknowledge reads 1. After that, idle=1, enabled=1 and on-pending=0.
- R6: An accepted power-off that leaves no vote drops the request output. The off-pending bit stays 1 until the acknowledge reads 0, and then for STAB_CYCLES more cycles. After that, idle=1, off-pending=0 and enabled=0.
- R7: A domain stays powered while any requester votes for it. A power-off write from the bus leaves the request and the enabled bit at 1 while a remote vote remains. Removing the last vote powers the domain down.
- R8: A remote vote on an idle, unpowered domain powers it up without any bus access.
- R9: A power-on or power-off write to a domain whose idle bit is 0 is ignored, and the domain's sticky error bit is set. Writing 1 to the error bit clears it.
- R10: Read data appears on the bus read port one cycle after the read strobe. It holds its value while no read is issued.
- R11: After reset every idle bit is 1, and the enabled, pending and error bits are 0. All request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | NUM_DOM | Write data, one bit per domain |
| bus_rdata | output | NUM_DOM | Registered read data |
| rmt_vote | input | (NUM_REQ-1)*NUM_DOM | Remote votes, requester r at bits [r*NUM_DOM +: NUM_DOM] |
| pwr_ack | input | NUM_DOM | Power switch acknowledge per domain |
| pwr_req | output | NUM_DOM | Power request per domain |

## Verification
A wrong engine state shows first in the command handshake. A command that is not started leaves the power-on bit stuck at 0 or the power-off bit stuck at 1 on the second read after the write. A lost vote or a wrong aggregation shows on the request output and on the enabled bit within a few cycles of the change. A settling counter of the wrong length shows as an off-pending bit that clears too early or too late against the acknowledge. Busy commands that are wrongly accepted change the request output or leave the error bit clear on the next read.

// File: rtl/pdv_pkg.sv
package pdv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ACPT     = 3'd1,
    ST_ON_WAIT  = 3'd2,
    ST_OFF_WAIT = 3'd3,
    ST_SETTLE   = 3'd4
  } dom_state_e;

  localparam int OFF_SET_CMD = 0;
  localparam int OFF_CLR_CMD = 4;
  localparam int OFF_IDLE    = 8;
  localparam int OFF_EN      = 12;
  localparam int OFF_ON_PND  = 16;
  localparam int OFF_OFF_PND = 20;
  localparam int OFF_ERR     = 24;

endpackage

// File: rtl/pdv_vote_merge.sv
module pdv_vote_merge #(
  parameter int NUM_DOM = 8,
  parameter int NUM_RMT = 2
) (
  input  logic [NUM_RMT*NUM_DOM-1:0] rmt_vote,
  output logic [NUM_DOM-1:0]         rmt_any
);

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    logic [NUM_RMT-1:0] col;
    for (genvar r = 0; r < NUM_RMT; r++) begin : g_req
      assign col[r] = rmt_vote[r*NUM_DOM + d];
    end
    assign rmt_any[d] = |col;
  end

endmodule

// File: rtl/pdv_regif.sv
module pdv_regif
  import pdv_pkg::*;
#(
  parameter int NUM_DOM = 8,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_DOM-1:0] bus_wdata,
  output logic [NUM_DOM-1:0] bus_rdata,
  output logic [NUM_DOM-1:0] set_cmd,
  output logic [NUM_DOM-1:0] clr_cmd,
  output logic [NUM_DOM-1:0] err_clr,
  input  logic [NUM_DOM-1:0] set_rd,
  input  logic [NUM_DOM-1:0] clr_rd,
  input  logic [NUM_DOM-1:0] idle,
  input  logic [NUM_DOM-1:0] en,
  input  logic [NUM_DOM-1:0] on_pnd,
  input  logic [NUM_DOM-1:0] off_pnd,
  input  logic [NUM_DOM-1:0] err
);

  logic hit_set, hit_clr, hit_idle, hit_en, hit_onp, hit_offp, hit_err;
  logic [NUM_DOM-1:0] rd_mux;

  assign hit_set  = (bus_addr == ADDR_W'(OFF_SET_CMD));
  assign hit_clr  = (bus_addr == ADDR_W'(OFF_CLR_CMD));
  assign hit_idle = (bus_addr == ADDR_W'(OFF_IDLE));
  assign hit_en   = (bus_addr == ADDR_W'(OFF_EN));
  assign hit_onp  = (bus_addr == ADDR_W'(OFF_ON_PND));
  assign hit_offp = (bus_addr == ADDR_W'(OFF_OFF_PND));
  assign hit_err  = (bus_addr == ADDR_W'(OFF_ERR));

  assign set_cmd = (bus_wr && hit_set) ? bus_wdata : '0;
  assign clr_cmd = (bus_wr && hit_clr) ? bus_wdata : '0;
  assign err_clr = (bus_wr && hit_err) ? bus_wdata : '0;

  always_comb begin
    rd_mux = '0;
    if (hit_set)  rd_mux = set_rd;
    if (hit_clr)  rd_mux = clr_rd;
    if (hit_idle) rd_mux = idle;
    if (hit_en)   rd_mux = en;
    if (hit_onp)  rd_mux = on_pnd;
    if (hit_offp) rd_mux = off_pnd;
    if (hit_err)  rd_mux = err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R10

  AST_ONE_CMD_KIND: assert property (@(posedge clk) disable iff (rst)
    $onehot0({|set_cmd, |clr_cmd, |err_clr})); // R1

endmodule

// File: rtl/pdv_domain.sv
module pdv_domain
  import pdv_pkg::*;
#(
  parameter int STAB_CYCLES = 25000
) (
  input  logic clk,
  input  logic rst,
  input  logic set_cmd,
  input  logic clr_cmd,
  input  logic err_clr,
  input  logic rmt_any,
  input  logic pwr_ack,
  output logic pwr_req,
  output logic idle,
  output logic on_pnd,
  output logic off_pnd,
  output logic set_rd,
  output logic clr_rd,
  output logic err
);

  localparam int CNT_W = $clog2(STAB_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STAB_CYCLES - 1);

  dom_state_e       state;
  logic             ap_vote;
  logic             agg;
  logic [CNT_W-1:0] cnt;
  logic             busy_cmd;

  assign agg      = ap_vote | rmt_any;
  assign idle     = (state == ST_IDLE);
  assign on_pnd   = (state == ST_ON_WAIT);
  assign off_pnd  = (state == ST_OFF_WAIT) || (state == ST_SETTLE);
  assign busy_cmd = (set_cmd || clr_cmd) && !idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      ap_vote <= 1'b0;
      pwr_req <= 1'b0;
      set_rd  <= 1'b1;
      clr_rd  <= 1'b0;
      err     <= 1'b0;
      cnt     <= '0;
    end else begin
      if (err_clr) err <= 1'b0;
      if (busy_cmd) err <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (set_cmd) begin
            ap_vote <= 1'b1;
            set_rd  <= 1'b0;
            state   <= ST_ACPT;
          end else if (clr_cmd) begin
            ap_vote <= 1'b0;
            clr_rd  <= 1'b1;
            state   <= ST_ACPT;
          end else if (agg != pwr_req) begin
            pwr_req <= agg;
            state   <= agg ? ST_ON_WAIT : ST_OFF_WAIT;
          end
        end
        ST_ACPT: begin
          set_rd <= 1'b1;
          clr_rd <= 1'b0;
          if (agg != pwr_req) begin
            pwr_req <= agg;
            state   <= agg ? ST_ON_WAIT : ST_OFF_WAIT;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_ON_WAIT: begin
          if (pwr_ack) state <= ST_IDLE;
        end
        ST_OFF_WAIT: begin
          if (!pwr_ack) begin
            cnt   <= '0;
            state <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (cnt == CNT_LAST) state <= ST_IDLE;
          else                 cnt   <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_SET_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (set_cmd && !idle) |=> $stable(ap_vote)); // R9

  AST_BUSY_ERR_RAISE: assert property (@(posedge clk) disable iff (rst)
    ((set_cmd || clr_cmd) && !idle) |=> err); // R9

  AST_ON_COMPLETE: assert property (@(posedge clk) disable iff (rst)
    (on_pnd && pwr_ack) |=> (idle && pwr_req)); // R5

  AST_OFF_REQ_LOW: assert property (@(posedge clk) disable iff (rst)
    off_pnd |-> !pwr_req); // R6

  AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETTLE) |-> (cnt <= CNT_LAST)); // R6

  AST_SET_HS_RETURN: assert property (@(posedge clk) disable iff (rst)
    $fell(set_rd) |=> set_rd); // R3

  AST_CLR_HS_DROP: assert property (@(posedge clk) disable iff (rst)
    $rose(clr_rd) |=> !clr_rd); // R4

  AST_VOTE_HELD: assert property (@(posedge clk) disable iff (rst)
    (idle && agg && !set_cmd && !clr_cmd) |=> pwr_req); // R7

endmodule

// File: rtl/pwr_vote_ctrl.sv
module pwr_vote_ctrl
  import pdv_pkg::*;
#(
  parameter int NUM_DOM     = 8,
  parameter int NUM_REQ     = 3,
  parameter int ADDR_W      = 8,
  parameter int STAB_CYCLES = 25000
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             bus_wr,
  input  logic                             bus_rd,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic [NUM_DOM-1:0]               bus_wdata,
  output logic [NUM_DOM-1:0]               bus_rdata,
  input  logic [(NUM_REQ-1)*NUM_DOM-1:0]   rmt_vote,
  input  logic [NUM_DOM-1:0]               pwr_ack,
  output logic [NUM_DOM-1:0]               pwr_req
);

  localparam int NUM_RMT = NUM_REQ - 1;

  logic [NUM_DOM-1:0] set_cmd, clr_cmd, err_clr, rmt_any;
  logic [NUM_DOM-1:0] idle, on_pnd, off_pnd, set_rd, clr_rd, err;

  pdv_vote_merge #(.NUM_DOM(NUM_DOM), .NUM_RMT(NUM_RMT)) u_merge (
    .rmt_vote (rmt_vote),
    .rmt_any  (rmt_any)
  );

  pdv_regif #(.NUM_DOM(NUM_DOM), .ADDR_W(ADDR_W)) u_regif (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .set_cmd   (set_cmd),
    .clr_cmd   (clr_cmd),
    .err_clr   (err_clr),
    .set_rd    (set_rd),
    .clr_rd    (clr_rd),
    .idle      (idle),
    .en        (pwr_req),
    .on_pnd    (on_pnd),
    .off_pnd   (off_pnd),
    .err       (err)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    pdv_domain #(.STAB_CYCLES(STAB_CYCLES)) u_dom (
      .clk     (clk),
      .rst     (rst),
      .set_cmd (set_cmd[d]),
      .clr_cmd (clr_cmd[d]),
      .err_clr (err_clr[d]),
      .rmt_any (rmt_any[d]),
      .pwr_ack (pwr_ack[d]),
      .pwr_req (pwr_req[d]),
      .idle    (idle[d]),
      .on_pnd  (on_pnd[d]),
      .off_pnd (off_pnd[d]),
      .set_rd  (set_rd[d]),
      .clr_rd  (clr_rd[d]),
      .err     (err[d])
    );
  end

  AST_REQ_ONLY_WITH_VOTE: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_req[0]) |-> $past(!idle[0] || rmt_any[0])); // R8

endmodule

// File: tb/pwr_vote_ctrl_bench.sv
module pwr_vote_ctrl_bench;

  localparam int ND   = 8;
  localparam int NR   = 3;
  localparam int AW   = 8;
  localparam int STAB = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [ND-1:0] bus_wdata = '0;
  logic [ND-1:0] bus_rdata;
  logic [(NR-1)*ND-1:0] rmt_vote = '0;
  logic [ND-1:0] pwr_ack, pwr_req;
  logic [ND-1:0] sr1, sr2, ack_q;
  logic [ND-1:0] ack_hold = '0;
  logic rd_pend;

  int n_chk = 0;
  int n_fail = 0;

  logic [ND-1:0] exp_q[$];
  string         tag_q[$];

  always #2 clk = ~clk;

  pwr_vote_ctrl #(.NUM_DOM(ND), .NUM_REQ(NR), .ADDR_W(AW), .STAB_CYCLES(STAB)) u_pwr_vote_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rmt_vote(rmt_vote),
    .pwr_ack(pwr_ack), .pwr_req(pwr_req)
  );

  // switch model: acknowledge follows request after three cycles unless held
  always @(posedge clk) begin
    if (rst) begin
      sr1 <= '0; sr2 <= '0; ack_q <= '0;
    end else begin
      sr1   <= (sr1 & ack_hold)   | (pwr_req & ~ack_hold);
      sr2   <= (sr2 & ack_hold)   | (sr1 & ~ack_hold);
      ack_q <= (ack_q & ack_hold) | (sr2 & ~ack_hold);
    end
  end
  assign pwr_ack = ack_q;

  always @(posedge clk) rd_pend <= bus_rd;

  task automatic chk(input bit ok, input string tag, input logic [ND-1:0] act, input logic [ND-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when read data is due
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "scoreboard underflow", bus_rdata, '0);
      end else begin
        logic [ND-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bus_rdata == e, t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input int addr, input logic [ND-1:0] data);
    bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input int addr, input logic [ND-1:0] exp, input string tag);
    bus_rd = 1'b1; bus_addr = AW'(addr);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    chk(pwr_req == '0, "R11 pwr_req after reset", pwr_req, '0);
    rd_exp(8,  8'hFF, "R11 idle after reset");
    rd_exp(12, 8'h00, "R11 enabled after reset");
    rd_exp(0,  8'hFF, "R3 power-on cmd reads ones after reset");
    rd_exp(4,  8'h00, "R4 power-off cmd reads zeros after reset");
    rd_exp(24, 8'h00, "R11 error after reset");

    // R3 / R5 power-on of domain 0 with acknowledge held low
    ack_hold = 8'h01;
    wr(0, 8'h01);
    rd_exp(0,  8'hFE, "R3 power-on bit reads 0 after write");
    rd_exp(0,  8'hFF, "R3 power-on bit returns to 1");
    rd_exp(8,  8'hFE, "R2 idle low while busy");
    rd_exp(16, 8'h01, "R5 on-pending while ack low");
    rd_exp(12, 8'h01, "R5 enabled on accept");
    chk(pwr_req == 8'h01, "R5 request raised", pwr_req, 8'h01);
    // R9 busy writes ignored
    wr(0, 8'h01);
    wr(4, 8'h01);
    rd_exp(24, 8'h01, "R9 error set by busy write");
    rd_exp(4,  8'h00, "R9 busy power-off not taken");
    ack_hold = 8'h00;
    wait_cyc(8);
    rd_exp(8,  8'hFF, "R5 idle after ack");
    rd_exp(12, 8'h01, "R5 enabled after ack");
    rd_exp(16, 8'h00, "R5 on-pending cleared");
    chk(pwr_req == 8'h01, "R9 busy power-off had no effect", pwr_req, 8'h01);
    rd_exp(24, 8'h01, "R9 error sticky");
    wr(24, 8'hFF);
    rd_exp(24, 8'h00, "R9 error cleared by write 1");
    wr(8, 8'h00);
    rd_exp(8,  8'hFF, "R1 write to idle register ignored");

    // R4 / R6 power-off of domain 0 with acknowledge held high
    ack_hold = 8'h01;
    wr(4, 8'h01);
    rd_exp(4,  8'h01, "R4 power-off bit reads 1 after write");
    rd_exp(4,  8'h00, "R4 power-off bit drops once started");
    chk(pwr_req == 8'h00, "R6 request dropped", pwr_req, 8'h00);
    rd_exp(20, 8'h01, "R6 off-pending while ack high");
    rd_exp(8,  8'hFE, "R2 idle low during power-off");
    ack_hold = 8'h00;
    wait_cyc(10);
    rd_exp(20, 8'h01, "R6 off-pending during settling");
    wait_cyc(30);
    rd_exp(20, 8'h00, "R6 off-pending cleared after settling");
    rd_exp(8,  8'hFF, "R6 idle after settling");
    rd_exp(12, 8'h00, "R6 enabled cleared");

    // R8 remote vote powers domain 2
    rmt_vote[2] = 1'b1;
    wait_cyc(10);
    chk(pwr_req[2] == 1'b1, "R8 remote vote raises request", {7'd0, pwr_req[2]}, 8'h01);
    rd_exp(12, 8'h04, "R8 enabled by remote vote");
    // R7 bus power-off while remote still votes
    wr(0, 8'h04);
    wait_cyc(10);
    wr(4, 8'h04);
    wait_cyc(10);
    rd_exp(12, 8'h04, "R7 enabled kept by remote vote");
    rd_exp(20, 8'h00, "R7 no off-pending while remote votes");
    chk(pwr_req[2] == 1'b1, "R7 request kept", {7'd0, pwr_req[2]}, 8'h01);
    rmt_vote[2] = 1'b0;
    wait_cyc(40);
    chk(pwr_req[2] == 1'b0, "R7 last vote removed", {7'd0, pwr_req[2]}, 8'h00);
    rd_exp(12, 8'h00, "R7 enabled cleared after last vote");

    // R7 two remote requesters on domain 5
    rmt_vote[5] = 1'b1;
    rmt_vote[ND+5] = 1'b1;
    wait_cyc(10);
    rd_exp(12, 8'h20, "R7 two remote votes");
    rmt_vote[5] = 1'b0;
    wait_cyc(40);
    rd_exp(12, 8'h20, "R7 one remote vote left");
    rmt_vote[ND+5] = 1'b0;
    wait_cyc(40);
    rd_exp(12, 8'h00, "R7 no remote vote left");

    // R1 several domains by bit position
    wr(0, 8'h18);
    wait_cyc(10);
    rd_exp(12, 8'h18, "R1 two domains enabled");
    chk(pwr_req == 8'h18, "R1 requests on bits 3 and 4", pwr_req, 8'h18);
    wr(4, 8'h08);
    wait_cyc(40);
    rd_exp(12, 8'h10, "R1 only bit 3 powered off");
    rd_exp(8,  8'hFF, "R2 all idle at end");
    rd_exp(0,  8'hFF, "R10 read data one cycle after strobe");
    wait_cyc(3);
    chk(bus_rdata == 8'hFF, "R10 read data held", bus_rdata, 8'hFF);

    wait_cyc(2);
    finish_run();
  end

endmodule